// File: doc/BRIEF.md
# Overwriting FIFO with occupancy tracking

A single-clock first-in first-out buffer of 16 eight-bit words. Writes and reads each use a wrapping address counter, and the words sit in a register file. Writes are synchronous and reads are asynchronous: the word at the head of the queue is always visible on the read data port, with no clock edge in between. An occupancy counter reports how many words the buffer holds. The full and empty flags are decoded from it.

Two corner cases keep the buffer consistent where a plain FIFO would drift:
- **Write into a full buffer with no read.** The buffer does not refuse the word. It also pushes the read pointer forward, so the oldest word is dropped and the new word takes its slot.
- **Read from an empty buffer with no write.** The buffer also pushes the write pointer forward, so the two pointers stay aligned. The data returned by that read has no meaning.

These two adjustments are called skip paths. The parameter `SKIP_EN` removes both of them at elaboration time. The bench runs the default, with the skip paths present.

Top module: `ovf_fifo`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, empty to 1 and full to 0. After reset, the first word written is the first word read.
- R2: Words leave in the order they were written. Read data shows the word at the head of the queue as soon as the read address changes, with no extra register stage.
- R3: The count never exceeds 16. Full is 1 exactly when the count is 16, and empty is 1 exactly when the count is 0.
- R4: Between one clock edge and the next, the count holds, rises by 1, falls by 1, or returns to 0 through reset.
- R5: A write with no read while the count is 16 discards the oldest word and stores the new word at the tail. The count stays 16, and the head becomes the next-oldest word.
- R6: A read with no write while the count is 0 leaves the count at 0. A word written afterwards is the next word shown on read data.
- R7: A read and a write in the same cycle, with a count from 1 to 15, leave the count unchanged. The head advances by one word and the new word is appended at the tail.
- R8: A read and a write in the same cycle do not use the skip paths. When the count is 0, the count stays 0 and the written word is consumed at once. When the count is 16, the count stays 16, the head advances and the new word goes to the tail.
- R9: The count always equals the wrapped distance between the write and read addresses, except when full, where the distance is 0 and the count is 16. The distance is (write − read) if write ≥ read, else (write + 16 − read).
- R10: A read moves the read address on the next clock edge. With no read and the buffer not full, the read address and read data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_data | input | 8 | Word to write |
| rd_en | input | 1 | Read request for this cycle; pops the head |
| rd_data | output | 8 | Word at the head of the queue (combinational) |
| full | output | 1 | Buffer holds 16 words |
| empty | output | 1 | Buffer holds no words |
| count | output | 5 | Number of stored words, 0 to 16 |

## Verification
A skip path and a simultaneous read and write can both be requested in the same cycle. The same-cycle case always wins, so the skip must stay off.

The bench provokes this overlap in three ways:
- It asserts both enables with the buffer exactly full.
- It asserts both enables with the buffer exactly empty.
- It runs a long biased random sweep that repeatedly drives the count to both limits while both enables toggle.

A queue model in the bench judges every cycle. It computes the expected count and head word from the requirements alone. The embedded properties check that the count still matches the wrapped pointer distance after each overlap.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    // Default geometry of the buffer.
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_DEPTH  = 16;

    // Action the occupancy counter takes in a cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_t;

    // Per-cycle pointer control, decided once in the top module.
    typedef struct packed {
        logic    push;     // a write request is accepted
        logic    pop;      // a read request is accepted
        logic    drop_old; // read pointer skips: overwrite oldest
        logic    realign;  // write pointer skips: empty read
        occ_op_t occ;      // counter action
    } ptr_ctl_t;

endpackage

// File: rtl/ovf_addr_gen.sv
module ovf_addr_gen #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    // Wrapping address counter; the depth is a power of two, so
    // it wraps naturally.
    always_ff @(posedge clk) begin
        if (rst)      addr <= '0;
        else if (adv) addr <= addr + AW'(1);
    end

endmodule

// File: rtl/ovf_store.sv
module ovf_store #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Synchronous write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read port.
    assign rdata = mem[raddr];

endmodule

// File: rtl/ovf_occupancy.sv
module ovf_occupancy
    import ovf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  occ_op_t       op,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (op)
                OCC_INC: count <= count + CW'(1);
                OCC_DEC: count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Capacity bound.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // Step size of the count between cycles.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count)) ||
                 (count == $past(count) + CW'(1)) ||
                 (count == $past(count) - CW'(1)) ||
                 (count == '0));

endmodule

// File: rtl/ovf_fifo.sv
module ovf_fifo
    import ovf_pkg::*;
#(
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned DEPTH   = DEF_DEPTH,
    parameter bit          SKIP_EN = 1'b1,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     count
);

    ptr_ctl_t      ctl;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          at_cap;
    logic          at_zero;

    assign at_cap  = (count >= CW'(DEPTH));
    assign at_zero = (count == '0);

    // Per-cycle decisions.
    always_comb begin
        ctl.push = wr_en;
        ctl.pop  = rd_en;
        ctl.occ  = OCC_HOLD;
        if (wr_en && !rd_en && !at_cap)  ctl.occ = OCC_INC;
        if (rd_en && !wr_en && !at_zero) ctl.occ = OCC_DEC;
    end

    // The skip paths exist only when SKIP_EN is set.
    generate
        if (SKIP_EN) begin : g_skip
            assign ctl.drop_old = wr_en && !rd_en && at_cap;
            assign ctl.realign  = rd_en && !wr_en && at_zero;
        end else begin : g_noskip
            assign ctl.drop_old = 1'b0;
            assign ctl.realign  = 1'b0;
        end
    endgenerate

    ovf_addr_gen #(.AW(AW)) u_wptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (ctl.push | ctl.realign),
        .addr (waddr)
    );

    ovf_addr_gen #(.AW(AW)) u_rptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (ctl.pop | ctl.drop_old),
        .addr (raddr)
    );

    ovf_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (ctl.push),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_data)
    );

    ovf_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst   (rst),
        .op    (ctl.occ),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    // Wrapped distance between the pointers.
    logic [CW-1:0] gap;
    assign gap = (waddr >= raddr) ? (CW'(waddr) - CW'(raddr))
                                  : (CW'(waddr) + CW'(DEPTH) - CW'(raddr));

    generate
        if (SKIP_EN) begin : g_gap_chk
            assert_count_matches_gap_R9: assert property (@(posedge clk) disable iff (rst)
                (count == gap) || ((count == CW'(DEPTH)) && (gap == '0)));
        end
    endgenerate

    assert_read_moves_raddr_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (raddr != $past(raddr)));

    assert_idle_holds_raddr_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !full) |=> $stable(raddr));

    assert_overwrite_stays_full_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && full) |=> full);

    assert_empty_read_stays_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && empty) |=> empty);

    assert_both_keep_count_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> $stable(count));

endmodule

// File: tb/tb_ovf_fifo.sv
module tb_ovf_fifo;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       full;
    logic       empty;
    logic [4:0] count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [7:0] q[$];

    always #4 clk = ~clk; // 125 MHz

    ovf_fifo dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .count(count)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the outputs with the queue model.
    task automatic chk_state(input string tag);
        chk(int'(count), q.size(), {tag, " count"});
        chk(int'(full),  int'(q.size() == DEPTH), {tag, " full (R3)"});
        chk(int'(empty), int'(q.size() == 0), {tag, " empty (R3)"});
        if (q.size() > 0) chk(int'(rd_data), int'(q[0]), {tag, " head (R2)"});
    endtask

    // Apply one cycle: inputs driven at the negedge, model updated at
    // the posedge, outputs sampled 1 ns after that posedge.
    task automatic step(input bit w, input logic [7:0] d, input bit r, input string tag);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        if (w && !r) begin
            if (q.size() == DEPTH) void'(q.pop_front());
            q.push_back(d);
        end else if (r && !w) begin
            if (q.size() > 0) void'(q.pop_front());
        end else if (r && w) begin
            if (q.size() > 0) begin
                void'(q.pop_front());
                q.push_back(d);
            end
        end
        #1;
        chk_state(tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(int'(count), 0, "R1 count");
        chk(int'(empty), 1, "R1 empty");
        chk(int'(full),  0, "R1 full");
        step(1, 8'h3C, 0, "R1 first write");
        chk(int'(rd_data), 8'h3C, "R1 first word at head");
        step(0, 8'h00, 1, "R1 drain");

        // R2/R3: fill to capacity
        for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, "R2 fill");
        chk(int'(full), 1, "R3 full at 16");

        // R5: overwrite while full
        for (int i = 0; i < 3; i++) step(1, 8'hE0 + 8'(i), 0, "R5 overwrite");
        chk(int'(count), 16, "R5 count stays 16");
        chk(int'(rd_data), 8'h13, "R5 head is next-oldest");

        // R8: read and write together while full
        step(1, 8'hF5, 1, "R8 both at full");
        chk(int'(rd_data), 8'h14, "R8 head advanced at full");
        chk(int'(count), 16, "R8 count stays 16");

        // R2: drain and check order
        while (q.size() > 0) step(0, 8'h00, 1, "R2 drain order");

        // R6: reads while empty, then a write
        for (int i = 0; i < 3; i++) step(0, 8'h00, 1, "R6 empty read");
        chk(int'(count), 0, "R6 count stays 0");
        step(1, 8'hA5, 0, "R6 write after empty read");
        chk(int'(rd_data), 8'hA5, "R6 pointers aligned");
        step(0, 8'h00, 1, "R6 drain");

        // R8: read and write together while empty
        step(1, 8'h77, 1, "R8 both at empty");
        chk(int'(count), 0, "R8 count stays 0");
        step(1, 8'h55, 0, "R8 follow-up write");
        chk(int'(rd_data), 8'h55, "R8 next write at head");

        // R7: read and write together mid-range
        for (int i = 0; i < 4; i++) step(1, 8'h20 + 8'(i), 0, "R7 prefill");
        chk(int'(count), 5, "R7 count 5");
        step(1, 8'h99, 1, "R7 both mid");
        chk(int'(count), 5, "R7 count unchanged");
        chk(int'(rd_data), 8'h20, "R7 head advanced");

        // R10: idle cycles hold the head
        prev = rd_data;
        for (int i = 0; i < 3; i++) step(0, 8'h00, 0, "R10 idle");
        chk(int'(rd_data), int'(prev), "R10 read data held");
        step(0, 8'h00, 1, "R10 read");
        chk(int'(rd_data), 8'h21, "R10 head moved after read");

        // R4/R9: biased random sweep across many wraps, both limits
        for (int i = 0; i < 4000; i++) begin
            int phase;
            bit w;
            bit r;
            phase = (i / 250) % 2;
            w = ($urandom % 100) < (phase ? 75 : 25);
            r = ($urandom % 100) < (phase ? 25 : 75);
            step(w, 8'($urandom), r, "R4 R9 sweep");
        end

        // R1: reset mid-stream clears occupancy
        rst = 1'b1;
        @(posedge clk);
        #1;
        q.delete();
        chk_state("R1 reset mid-stream");
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule